// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Sequencer

This block moves a processor core from one voltage/frequency operating point to another. Software writes a target point, made of a 6-bit voltage code and a clock ratio. The sequencer then orders the change so that the supply is never too low for the clock. On a rise in ratio it ramps the voltage code first and relocks the PLL afterwards. On a fall in ratio it relocks the PLL first and lowers the voltage afterwards. The voltage code moves one step per settle strobe from the regulator model. While the PLL relocks, the core is stalled and snoops are held off.

A second source of requests is thermal protection. While the hot flag is raised, the block drops to a programmable low point and pulses an interrupt. It then waits a fixed number of cycles and checks the flag again. If the flag has cleared, it returns to the software target and pulses the interrupt again. If not, it waits another full period. The regulator, the PLL and the sensor lie outside the block and are modelled by single-cycle strobes and a level flag.

Top module: `vf_step_top`

## Requirements
- R1: When the target ratio is higher than the current ratio, the voltage code is stepped to its target first. The ratio output changes only on the settle strobe that arrives after the voltage code has reached the target.
- R2: When the target ratio is lower than the current ratio, the ratio output changes first, in the cycle the transition starts. The voltage code changes only after the PLL-lock strobe.
- R3: A software request written while a transition is running is held. It starts one cycle after the running transition ends, and the point it carries is the last one written.
- R4: `core_stall_o` and `snoop_block_o` are high exactly while the block waits for PLL lock. `ratio_o` changes only at the start of such a wait, and `vid_o` does not change during the wait.
- R5: `vid_o` moves by exactly one code at a time. The first step is taken when a voltage phase starts, and each later step on a settle strobe, until the code equals the target.
- R6: `busy_o` rises the second clock edge after a software write seen while idle. It stays high until the last required lock or settle strobe has been taken.
- R7: While the hot flag is high and no transition is running, the block starts a transition to the programmed low point. `therm_irq_o` is high for exactly one cycle at that start.
- R8: Once the thermal down-shift ends, the block waits HOLD_CYCLES cycles and then samples the hot flag. If the flag is still high, it waits another HOLD_CYCLES cycles. If the flag is low, it starts the return to the software target with a one-cycle `therm_irq_o` pulse.
- R9: A software write made during thermal throttling changes no output. It becomes the point that the thermal return goes to.
- R10: After reset, `vid_o` equals RST_VID and `ratio_o` equals RST_RATIO, and `busy_o`, `core_stall_o`, `snoop_block_o` and `therm_irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_we_i | input | 1 | Software target write strobe |
| req_vid_i | input | 6 | Voltage code of the software target |
| req_ratio_i | input | 5 | Clock ratio of the software target |
| low_we_i | input | 1 | Write strobe for the thermal low point |
| low_vid_i | input | 6 | Voltage code of the thermal low point |
| low_ratio_i | input | 5 | Clock ratio of the thermal low point |
| temp_hot_i | input | 1 | Die-too-hot level flag |
| pll_lock_i | input | 1 | One-cycle PLL lock strobe |
| vid_settled_i | input | 1 | One-cycle regulator settle strobe |
| vid_o | output | 6 | Voltage code driven to the regulator |
| ratio_o | output | 5 | Clock ratio driven to the PLL |
| core_stall_o | output | 1 | Core stalled while the PLL relocks |
| snoop_block_o | output | 1 | Snoops held off while the PLL relocks |
| busy_o | output | 1 | A transition is in progress |
| therm_irq_o | output | 1 | One-cycle pulse on a thermal shift down or back up |

## Verification
A software write is registered on one edge and starts the sequencer on the next. The bench therefore samples `busy_o` and the first voltage step on the second falling edge after the write, and first confirms that nothing has moved one edge earlier. Lock and settle strobes are driven for exactly one cycle. Every output change they cause is read on the falling edge right after the edge that took them, which also shows that a deferred request starts one cycle after the previous transition ends. The thermal return is timed by counting falling edges from the end of the down-shift until the interrupt appears, and the count is compared with 2*HOLD_CYCLES+1 because the flag is held high across the first expiry.

// File: rtl/vf_seq_pkg.sv
package vf_seq_pkg;

    parameter int unsigned VID_W   = 6;
    parameter int unsigned RATIO_W = 5;

    typedef struct packed {
        logic [VID_W-1:0]   vid;
        logic [RATIO_W-1:0] ratio;
    } op_point_t;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_VOLT_FIRST,
        RS_LOCK_LAST,
        RS_LOCK_FIRST,
        RS_VOLT_LAST,
        RS_NOP
    } ramp_st_e;

    typedef enum logic [1:0] {
        PM_NORMAL,
        PM_SHED,
        PM_HOLD
    } pol_mode_e;

    // one code toward the target, never more
    function automatic logic [VID_W-1:0] vid_toward(input logic [VID_W-1:0] cur,
                                                    input logic [VID_W-1:0] tgt);
        if (cur < tgt)      return cur + 1'b1;
        else if (cur > tgt) return cur - 1'b1;
        else                return cur;
    endfunction

endpackage

// File: rtl/vf_hold_timer.sv
module vf_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = CW'(HOLD_CYCLES - 1);
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign expire_o = tmr_q.run && (tmr_q.cnt == '0);

endmodule

// File: rtl/vf_ramp.sv
module vf_ramp
    import vf_seq_pkg::*;
#(
    parameter int unsigned RST_VID   = 20,
    parameter int unsigned RST_RATIO = 8
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  op_point_t tgt_i,
    input  logic      settled_i,
    input  logic      lock_i,
    output op_point_t cur_o,
    output logic      busy_o,
    output logic      relock_o
);
    typedef struct packed {
        ramp_st_e  st;
        op_point_t cur;
        op_point_t tgt;
    } ramp_t;

    ramp_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RS_IDLE: begin
                if (start_i) begin
                    r_d.tgt = tgt_i;
                    if (tgt_i.ratio > r_q.cur.ratio) begin
                        if (tgt_i.vid != r_q.cur.vid) begin
                            r_d.st      = RS_VOLT_FIRST;
                            r_d.cur.vid = vid_toward(r_q.cur.vid, tgt_i.vid);
                        end else begin
                            r_d.st        = RS_LOCK_LAST;
                            r_d.cur.ratio = tgt_i.ratio;
                        end
                    end else if (tgt_i.ratio < r_q.cur.ratio) begin
                        r_d.st        = RS_LOCK_FIRST;
                        r_d.cur.ratio = tgt_i.ratio;
                    end else if (tgt_i.vid != r_q.cur.vid) begin
                        r_d.st      = RS_VOLT_LAST;
                        r_d.cur.vid = vid_toward(r_q.cur.vid, tgt_i.vid);
                    end else begin
                        r_d.st = RS_NOP;
                    end
                end
            end
            RS_VOLT_FIRST: begin
                if (settled_i) begin
                    if (r_q.cur.vid == r_q.tgt.vid) begin
                        r_d.st        = RS_LOCK_LAST;
                        r_d.cur.ratio = r_q.tgt.ratio;
                    end else begin
                        r_d.cur.vid = vid_toward(r_q.cur.vid, r_q.tgt.vid);
                    end
                end
            end
            RS_LOCK_LAST: begin
                if (lock_i) r_d.st = RS_IDLE;
            end
            RS_LOCK_FIRST: begin
                if (lock_i) begin
                    if (r_q.cur.vid != r_q.tgt.vid) begin
                        r_d.st      = RS_VOLT_LAST;
                        r_d.cur.vid = vid_toward(r_q.cur.vid, r_q.tgt.vid);
                    end else begin
                        r_d.st = RS_IDLE;
                    end
                end
            end
            RS_VOLT_LAST: begin
                if (settled_i) begin
                    if (r_q.cur.vid == r_q.tgt.vid) r_d.st = RS_IDLE;
                    else r_d.cur.vid = vid_toward(r_q.cur.vid, r_q.tgt.vid);
                end
            end
            RS_NOP:  r_d.st = RS_IDLE;
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.st        <= RS_IDLE;
            r_q.cur.vid   <= VID_W'(RST_VID);
            r_q.cur.ratio <= RATIO_W'(RST_RATIO);
            r_q.tgt.vid   <= VID_W'(RST_VID);
            r_q.tgt.ratio <= RATIO_W'(RST_RATIO);
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_o    = r_q.cur;
    assign busy_o   = (r_q.st != RS_IDLE);
    assign relock_o = (r_q.st == RS_LOCK_LAST) || (r_q.st == RS_LOCK_FIRST);

endmodule

// File: rtl/vf_policy.sv
module vf_policy
    import vf_seq_pkg::*;
#(
    parameter int unsigned RST_VID   = 20,
    parameter int unsigned RST_RATIO = 8,
    parameter int unsigned LOW_VID   = 12,
    parameter int unsigned LOW_RATIO = 6
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      req_we_i,
    input  op_point_t req_pt_i,
    input  logic      low_we_i,
    input  op_point_t low_pt_i,
    input  logic      hot_i,
    input  logic      ramp_busy_i,
    input  logic      expire_i,
    output logic      start_o,
    output op_point_t tgt_o,
    output logic      load_o,
    output logic      irq_o
);
    typedef struct packed {
        pol_mode_e mode;
        op_point_t sw_tgt;
        logic      sw_pend;
        op_point_t low;
        logic      irq;
    } pol_t;

    pol_t p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.irq = 1'b0;
        start_o = 1'b0;
        tgt_o   = p_q.sw_tgt;
        load_o  = 1'b0;
        if (low_we_i) p_d.low = low_pt_i;
        if (req_we_i) p_d.sw_tgt = req_pt_i;
        case (p_q.mode)
            PM_NORMAL: begin
                if (req_we_i) p_d.sw_pend = 1'b1;
                if (!ramp_busy_i) begin
                    if (hot_i) begin
                        start_o     = 1'b1;
                        tgt_o       = p_q.low;
                        p_d.mode    = PM_SHED;
                        p_d.irq     = 1'b1;
                        p_d.sw_pend = 1'b0;
                    end else if (p_q.sw_pend) begin
                        start_o     = 1'b1;
                        tgt_o       = p_q.sw_tgt;
                        p_d.sw_pend = req_we_i;
                    end
                end
            end
            PM_SHED: begin
                if (!ramp_busy_i) begin
                    p_d.mode = PM_HOLD;
                    load_o   = 1'b1;
                end
            end
            PM_HOLD: begin
                if (expire_i) begin
                    if (hot_i) begin
                        load_o = 1'b1;
                    end else begin
                        start_o     = 1'b1;
                        tgt_o       = p_q.sw_tgt;
                        p_d.mode    = PM_NORMAL;
                        p_d.irq     = 1'b1;
                        p_d.sw_pend = req_we_i;
                    end
                end
            end
            default: p_d.mode = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p_q.mode         <= PM_NORMAL;
            p_q.sw_tgt.vid   <= VID_W'(RST_VID);
            p_q.sw_tgt.ratio <= RATIO_W'(RST_RATIO);
            p_q.sw_pend      <= 1'b0;
            p_q.low.vid      <= VID_W'(LOW_VID);
            p_q.low.ratio    <= RATIO_W'(LOW_RATIO);
            p_q.irq          <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign irq_o = p_q.irq;

endmodule

// File: rtl/vf_step_top.sv
module vf_step_top
    import vf_seq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 40,
    parameter int unsigned RST_VID     = 20,
    parameter int unsigned RST_RATIO   = 8,
    parameter int unsigned LOW_VID     = 12,
    parameter int unsigned LOW_RATIO   = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_we_i,
    input  logic [VID_W-1:0]   req_vid_i,
    input  logic [RATIO_W-1:0] req_ratio_i,
    input  logic               low_we_i,
    input  logic [VID_W-1:0]   low_vid_i,
    input  logic [RATIO_W-1:0] low_ratio_i,
    input  logic               temp_hot_i,
    input  logic               pll_lock_i,
    input  logic               vid_settled_i,
    output logic [VID_W-1:0]   vid_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               core_stall_o,
    output logic               snoop_block_o,
    output logic               busy_o,
    output logic               therm_irq_o
);
    op_point_t req_pt, low_pt, tgt, cur;
    logic      start, load, expire, relock, ramp_busy;

    assign req_pt = '{vid: req_vid_i, ratio: req_ratio_i};
    assign low_pt = '{vid: low_vid_i, ratio: low_ratio_i};

    vf_policy #(
        .RST_VID  (RST_VID),
        .RST_RATIO(RST_RATIO),
        .LOW_VID  (LOW_VID),
        .LOW_RATIO(LOW_RATIO)
    ) i_policy (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_we_i   (req_we_i),
        .req_pt_i   (req_pt),
        .low_we_i   (low_we_i),
        .low_pt_i   (low_pt),
        .hot_i      (temp_hot_i),
        .ramp_busy_i(ramp_busy),
        .expire_i   (expire),
        .start_o    (start),
        .tgt_o      (tgt),
        .load_o     (load),
        .irq_o      (therm_irq_o)
    );

    vf_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) i_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .expire_o(expire)
    );

    vf_ramp #(
        .RST_VID  (RST_VID),
        .RST_RATIO(RST_RATIO)
    ) i_ramp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .tgt_i    (tgt),
        .settled_i(vid_settled_i),
        .lock_i   (pll_lock_i),
        .cur_o    (cur),
        .busy_o   (ramp_busy),
        .relock_o (relock)
    );

    assign vid_o         = cur.vid;
    assign ratio_o       = cur.ratio;
    assign busy_o        = ramp_busy;
    assign core_stall_o  = relock;
    assign snoop_block_o = relock;

endmodule

// File: rtl/vf_step_checks.sv
module vf_step_checks
    import vf_seq_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [VID_W-1:0]   vid_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic               core_stall_o,
    input logic               snoop_block_o,
    input logic               busy_o,
    input logic               therm_irq_o
);
    AST_VID_ONE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vid_o) |-> ((vid_o == $past(vid_o) + 1'b1) || ($past(vid_o) == vid_o + 1'b1))); // R5

    AST_RATIO_MOVES_IN_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ratio_o) |-> (core_stall_o && snoop_block_o)); // R4

    AST_VID_HELD_IN_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_stall_o |-> $stable(vid_o)); // R4

    AST_STALL_WITHIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_stall_o || snoop_block_o) |-> busy_o); // R6

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        therm_irq_o |=> !therm_irq_o); // R7

    AST_RATIO_UP_VID_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_o > $past(ratio_o)) |-> $stable(vid_o)); // R1

endmodule

bind vf_step_top vf_step_checks i_vf_step_checks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vid_o        (vid_o),
    .ratio_o      (ratio_o),
    .core_stall_o (core_stall_o),
    .snoop_block_o(snoop_block_o),
    .busy_o       (busy_o),
    .therm_irq_o  (therm_irq_o)
);

// File: tb/test_vf_step_top.sv
module test_vf_step_top;
    localparam int HOLD = 40;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       req_we_i = 1'b0;
    logic [5:0] req_vid_i = '0;
    logic [4:0] req_ratio_i = '0;
    logic       low_we_i = 1'b0;
    logic [5:0] low_vid_i = '0;
    logic [4:0] low_ratio_i = '0;
    logic       temp_hot_i = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic       vid_settled_i = 1'b0;
    logic [5:0] vid_o;
    logic [4:0] ratio_o;
    logic       core_stall_o, snoop_block_o, busy_o, therm_irq_o;

    int total = 0;
    int bad   = 0;

    always #5 clk_i = ~clk_i;

    vf_step_top #(.HOLD_CYCLES(HOLD)) i_vf_step_top (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .req_we_i(req_we_i), .req_vid_i(req_vid_i), .req_ratio_i(req_ratio_i),
        .low_we_i(low_we_i), .low_vid_i(low_vid_i), .low_ratio_i(low_ratio_i),
        .temp_hot_i(temp_hot_i), .pll_lock_i(pll_lock_i), .vid_settled_i(vid_settled_i),
        .vid_o(vid_o), .ratio_o(ratio_o), .core_stall_o(core_stall_o),
        .snoop_block_o(snoop_block_o), .busy_o(busy_o), .therm_irq_o(therm_irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_req(input int v, input int r);
        @(negedge clk_i);
        req_we_i = 1'b1; req_vid_i = 6'(v); req_ratio_i = 5'(r);
        @(negedge clk_i);
        req_we_i = 1'b0;
    endtask

    task automatic pulse_settle();
        @(negedge clk_i); vid_settled_i = 1'b1;
        @(negedge clk_i); vid_settled_i = 1'b0;
    endtask

    task automatic pulse_lock();
        @(negedge clk_i); pll_lock_i = 1'b1;
        @(negedge clk_i); pll_lock_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R10", "vid", vid_o, 20);
        chk("R10", "ratio", ratio_o, 8);
        chk("R10", "busy/stall/snoop/irq", {busy_o, core_stall_o, snoop_block_o, therm_irq_o}, 0);
    endtask

    task automatic t_up();
        wr_req(23, 12);
        chk("R6", "busy one edge after write", busy_o, 0);
        @(negedge clk_i);
        chk("R6", "busy two edges after write", busy_o, 1);
        chk("R5", "first vid step", vid_o, 21);
        chk("R1", "ratio held during voltage phase", ratio_o, 8);
        pulse_settle();
        chk("R5", "second vid step", vid_o, 22);
        pulse_settle();
        chk("R5", "vid at target", vid_o, 23);
        chk("R1", "ratio held until settle after target", ratio_o, 8);
        pulse_settle();
        chk("R1", "ratio after final settle", ratio_o, 12);
        chk("R4", "stall+snoop during relock", {core_stall_o, snoop_block_o}, 3);
        pulse_lock();
        chk("R6", "busy after lock", busy_o, 0);
        chk("R4", "stall released", core_stall_o, 0);
    endtask

    task automatic t_down();
        wr_req(21, 9);
        @(negedge clk_i);
        chk("R2", "ratio changes first", ratio_o, 9);
        chk("R2", "vid held before lock", vid_o, 23);
        chk("R4", "stall in relock", snoop_block_o, 1);
        pulse_lock();
        chk("R2", "vid step after lock", vid_o, 22);
        chk("R4", "stall off in voltage phase", core_stall_o, 0);
        pulse_settle();
        chk("R5", "vid at target", vid_o, 21);
        chk("R6", "busy until final settle", busy_o, 1);
        pulse_settle();
        chk("R6", "busy after final settle", busy_o, 0);
    endtask

    task automatic t_defer();
        wr_req(21, 11);
        @(negedge clk_i);
        chk("R3", "first request relocking", ratio_o, 11);
        wr_req(30, 11);
        wr_req(22, 11);
        chk("R3", "held request not applied", vid_o, 21);
        chk("R3", "still busy with first", busy_o, 1);
        pulse_lock();
        chk("R3", "idle one cycle between", busy_o, 0);
        @(negedge clk_i);
        chk("R3", "deferred request started", busy_o, 1);
        chk("R3", "last write wins", vid_o, 22);
        pulse_settle();
        chk("R3", "deferred request done", busy_o, 0);
    endtask

    task automatic t_thermal();
        int n;
        int guard;
        @(negedge clk_i);
        low_we_i = 1'b1; low_vid_i = 6'd15; low_ratio_i = 5'd6;
        @(negedge clk_i);
        low_we_i = 1'b0;
        temp_hot_i = 1'b1;
        @(negedge clk_i);
        chk("R7", "irq on down-shift", therm_irq_o, 1);
        chk("R7", "ratio to low point", ratio_o, 6);
        pulse_lock();
        chk("R7", "irq single cycle", therm_irq_o, 0);
        guard = 0;
        while (busy_o && guard < 20) begin
            pulse_settle();
            guard++;
        end
        chk("R7", "vid at low point", vid_o, 15);
        chk("R7", "ratio at low point", ratio_o, 6);
        n = 0;
        while (n < 300) begin
            @(negedge clk_i);
            n++;
            if (n == 10) begin
                req_we_i = 1'b1; req_vid_i = 6'd24; req_ratio_i = 5'd13;
            end
            if (n == 11) req_we_i = 1'b0;
            if (n == 20) begin
                chk("R9", "write during throttle: vid", vid_o, 15);
                chk("R9", "write during throttle: ratio", ratio_o, 6);
                chk("R9", "write during throttle: busy", busy_o, 0);
            end
            if (n == HOLD + 5) temp_hot_i = 1'b0;
            if (therm_irq_o) break;
        end
        chk("R8", "cycles to restore irq", n, 2 * HOLD + 1);
        chk("R8", "restore started", busy_o, 1);
        chk("R8", "restore first vid step", vid_o, 16);
        guard = 0;
        while (!core_stall_o && guard < 20) begin
            pulse_settle();
            guard++;
        end
        pulse_lock();
        chk("R9", "restored vid", vid_o, 24);
        chk("R9", "restored ratio", ratio_o, 13);
        chk("R6", "idle after restore", busy_o, 0);
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_defer();
        t_thermal();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule